// File: doc/BRIEF.md
# Watchdog Countdown Timer with Register Access

This block is a watchdog timer reached through a small strobe-based register interface. Software loads a 16-bit timeout in ticks of a fixed period, with 10 ms as the intended tick. It then arms or pings the timer by setting a reload bit in a one-byte control register. A prescaler divides the system clock down to one tick pulse. While enabled, the live counter drops by one on each tick. When the counter reaches zero, a one-clock reset request is raised for the system reset logic, and the counter stays at zero until software reloads it.

Before expiry, the counter passes a low-water level. At that level a sticky warning flag is set and, if warnings are enabled, an interrupt line is raised. A read of the count register returns the live remaining ticks, so software can work out the time left. Software forces an immediate restart by loading a timeout of one tick and then setting enable and reload together.

Top module: `wdt_countdown`

## Requirements
- R1: After hardware reset the control byte reads 0x00, the count register reads 0xFFFF, the threshold register reads 0x0000, and `sys_reset_req` and `warn_irq` are low.
- R2: Register decode works as follows. The count register is at byte offset 0x10 (low byte 0x10, high byte 0x11). The threshold register is at 0x12 (low byte) and 0x13 (high byte). The control byte is at 0x16. A halfword access uses all 16 data bits. A byte access uses bits 7:0 and reads back with bits 15:8 zero. Read data appears on the clock after the strobe. A write to the count register stores the preset only, and a read returns the live counter.
- R3: Writing control bit 2 as 1 copies the preset into the live counter on the next clock. Bit 2 then reads back as 0.
- R4: A tick occurs once every `TICK_DIV` clocks. With control bit 0 set, the live counter falls by exactly N over any N*`TICK_DIV` clocks, provided it stays above zero.
- R5: With control bit 0 clear, the live counter does not change. Control bits 0 and 3 hold the values last written.
- R6: When an enabled counter steps from 1 to 0, `sys_reset_req` is high for exactly one clock. The counter then holds at 0 with no further pulses until it is reloaded.
- R7: A preset of 1 followed by a control write of 0x05 raises `sys_reset_req` within `TICK_DIV`+2 clocks of that write.
- R8: Control bit 7 is set when the live counter reaches the warning level. That level is the threshold register when it is nonzero, and otherwise the preset shifted right by 3.
- R9: `warn_irq` is high exactly while control bits 7 and 3 are both 1.
- R10: Writing 1 to control bit 7 clears it. Writing 0 to bit 7 leaves it unchanged.
- R11: Control bit 0 changes only through a control write or a hardware reset. It still reads 1 after an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one clock per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_half | input | 1 | 1 for halfword access, 0 for byte access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data; byte accesses use bits 7:0 |
| bus_rdata | output | 16 | Read data, registered one clock after the strobe |
| sys_reset_req | output | 1 | One-clock reset request on expiry |
| warn_irq | output | 1 | Warning interrupt |

## Verification
Directed patterns cover the main paths. Split byte writes against halfword writes show whether the lane merge and the preset-versus-live split are right. A disabled interval against an enabled interval separates gating from counting. A ping part-way through a countdown shows that reload takes priority over a tick. The one-tick preset exercises the forced-restart timing. Randomised presets and thresholds, with the threshold sometimes left at zero to select the automatic level, check that the counter reads the expected level at the moment of warning and that exactly one reset pulse follows. Those checks together separate the threshold select, the level arithmetic and the expiry edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W      = 16;
  localparam int OFS_COUNT  = 16;
  localparam int OFS_THRESH = 18;
  localparam int OFS_CTRL   = 22;
  localparam int BIT_EN     = 0;
  localparam int BIT_RLD    = 2;
  localparam int BIT_NMI    = 3;
  localparam int BIT_WARN   = 7;

  // merge a byte or halfword write into a 16-bit register
  function automatic logic [CNT_W-1:0] lane_merge(input logic [CNT_W-1:0] old_v,
                                                  input logic [CNT_W-1:0] wd,
                                                  input logic hi_byte,
                                                  input logic half);
    if (half)         return wd;
    else if (hi_byte) return {wd[7:0], old_v[7:0]};
    else              return {old_v[15:8], wd[7:0]};
  endfunction

  // select the read lane of a 16-bit register
  function automatic logic [CNT_W-1:0] lane_pick(input logic [CNT_W-1:0] v,
                                                 input logic hi_byte,
                                                 input logic half);
    if (half)         return v;
    else if (hi_byte) return {8'h00, v[15:8]};
    else              return {8'h00, v[7:0]};
  endfunction

  // warning level: explicit threshold, or one eighth of the preset
  function automatic logic [CNT_W-1:0] warn_level(input logic [CNT_W-1:0] preset,
                                                  input logic [CNT_W-1:0] thr);
    return (thr != '0) ? thr : (preset >> 3);
  endfunction

  function automatic logic [7:0] ctrl_pack(input logic en, input logic rld,
                                           input logic nmi, input logic warn);
    logic [7:0] b;
    b = 8'h00;
    b[BIT_EN]   = en;
    b[BIT_RLD]  = rld;
    b[BIT_NMI]  = nmi;
    b[BIT_WARN] = warn;
    return b;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (div_q == LAST)  div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end

      assign tick = (div_q == LAST);

      p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick)
        else $error("tick pulses back to back");
    end
  endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core import wdt_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             reload,
  input  logic [CNT_W-1:0] preset,
  input  logic [CNT_W-1:0] level,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req,
  output logic             warn_hit
);
  logic [CNT_W-1:0] cnt_q;
  logic             rst_req_q;
  logic             dec_ev;
  logic             expire_ev;

  // named internal events
  assign dec_ev    = tick && en && !reload && (cnt_q != '0);
  assign expire_ev = dec_ev && (cnt_q == CNT_W'(1));
  assign warn_hit  = dec_ev && ((cnt_q - CNT_W'(1)) == level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '1;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= expire_ev;
      if (reload)      cnt_q <= preset;
      else if (dec_ev) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = rst_req_q;

  p_reload_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(preset)))
    else $error("reload did not copy preset");

  p_frozen_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reload) |=> $stable(cnt_q))
    else $error("counter moved while disabled");

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> !rst_req_q)
    else $error("reset request longer than one clock");

  p_pulse_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |-> (cnt_q == '0))
    else $error("reset request with nonzero count");
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              warn_hit,
  output logic [CNT_W-1:0]  preset,
  output logic [CNT_W-1:0]  threshold,
  output logic              en,
  output logic              reload,
  output logic              nmi_en,
  output logic              warn_flag
);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_THR = ADDR_W'(OFS_THRESH);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTRL);

  logic hit_cnt, hit_thr, hit_ctl;
  logic wr_cnt, wr_thr, wr_ctl, rd_ev;
  logic hi_byte;

  logic [CNT_W-1:0] preset_q, thr_q;
  logic en_q, rld_q, nmi_q, warn_q;

  assign hi_byte = bus_addr[0];
  assign hit_cnt = (bus_addr[ADDR_W-1:1] == A_CNT[ADDR_W-1:1]);
  assign hit_thr = (bus_addr[ADDR_W-1:1] == A_THR[ADDR_W-1:1]);
  assign hit_ctl = (bus_addr == A_CTL);

  assign wr_cnt = bus_sel && bus_wr && hit_cnt;
  assign wr_thr = bus_sel && bus_wr && hit_thr;
  assign wr_ctl = bus_sel && bus_wr && hit_ctl;
  assign rd_ev  = bus_sel && !bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '1;
      thr_q    <= '0;
      en_q     <= 1'b0;
      rld_q    <= 1'b0;
      nmi_q    <= 1'b0;
      warn_q   <= 1'b0;
    end else begin
      if (wr_cnt) preset_q <= lane_merge(preset_q, bus_wdata, hi_byte, bus_half);
      if (wr_thr) thr_q    <= lane_merge(thr_q, bus_wdata, hi_byte, bus_half);
      if (wr_ctl) begin
        en_q  <= bus_wdata[BIT_EN];
        nmi_q <= bus_wdata[BIT_NMI];
      end
      rld_q <= wr_ctl && bus_wdata[BIT_RLD];
      if (warn_hit)                             warn_q <= 1'b1;
      else if (wr_ctl && bus_wdata[BIT_WARN])   warn_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_ev) begin
      if (hit_cnt)      bus_rdata <= lane_pick(live_cnt, hi_byte, bus_half);
      else if (hit_thr) bus_rdata <= lane_pick(thr_q, hi_byte, bus_half);
      else if (hit_ctl) bus_rdata <= {8'h00, ctrl_pack(en_q, rld_q, nmi_q, warn_q)};
      else              bus_rdata <= '0;
    end
  end

  assign preset    = preset_q;
  assign threshold = thr_q;
  assign en        = en_q;
  assign reload    = rld_q;
  assign nmi_en    = nmi_q;
  assign warn_flag = warn_q;

  p_reload_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_q && !wr_ctl) |=> !rld_q)
    else $error("reload bit did not self-clear");

  p_warn_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q && !(wr_ctl && bus_wdata[BIT_WARN])) |=> warn_q)
    else $error("warning flag dropped without a clearing write");

  p_enable_by_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(en_q))
    else $error("enable changed without a control write");
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown import wdt_pkg::*; #(
  parameter int TICK_DIV = 1000,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_half,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sys_reset_req,
  output logic              warn_irq
);
  logic             tick;
  logic [CNT_W-1:0] live_cnt, preset, threshold, level;
  logic             en, reload, nmi_en, warn_flag, warn_hit;

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .live_cnt(live_cnt), .warn_hit(warn_hit),
    .preset(preset), .threshold(threshold),
    .en(en), .reload(reload), .nmi_en(nmi_en), .warn_flag(warn_flag)
  );

  assign level = warn_level(preset, threshold);

  wdt_core u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .reload(reload),
    .preset(preset), .level(level),
    .cnt(live_cnt), .rst_req(sys_reset_req), .warn_hit(warn_hit)
  );

  assign warn_irq = warn_flag && nmi_en;
endmodule

// File: tb/wdt_countdown_test.sv
module wdt_countdown_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        sys_reset_req, warn_irq;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_countdown #(.TICK_DIV(DIV), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_reset_req(sys_reset_req), .warn_irq(warn_irq)
  );

  always @(negedge clk) if (rst_n && sys_reset_req) pulses++;

  function automatic logic [15:0] exp_level(input logic [15:0] p, input logic [15:0] t);
    if (t != 16'd0) return t;
    return p / 16'd8;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input bit half, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_half = half; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit half, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_half = half; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_warn(input int limit, output bit seen);
    logic [15:0] c;
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      rd(8'h16, 1'b0, c);
      if (c[7]) seen = 1'b1;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] v, c0, c1;
    int base, k, seed;
    bit seen;
    seed = $urandom(32'd4242);

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    check(!sys_reset_req && !warn_irq, "R1 outputs", {30'd0, sys_reset_req, warn_irq}, 0);
    rd(8'h16, 1'b0, v); check(v == 16'h0000, "R1 ctrl", v, 16'h0000);
    rd(8'h10, 1'b1, v); check(v == 16'hFFFF, "R1 count", v, 16'hFFFF);
    rd(8'h12, 1'b1, v); check(v == 16'h0000, "R1 threshold", v, 16'h0000);
    rd(8'h11, 1'b0, v); check(v == 16'h00FF, "R2 byte read high", v, 16'h00FF);

    // R2 byte writes store preset only
    wr(8'h10, 1'b0, 16'hAB34);
    wr(8'h11, 1'b0, 16'hCD12);
    rd(8'h10, 1'b1, v); check(v == 16'hFFFF, "R2 live not preset", v, 16'hFFFF);
    // R3 reload without enable
    wr(8'h16, 1'b0, 16'h0004);
    idle(1);
    rd(8'h10, 1'b1, v); check(v == 16'h1234, "R3 reload copies preset", v, 16'h1234);
    rd(8'h10, 1'b0, v); check(v == 16'h0034, "R2 byte read low", v, 16'h0034);
    rd(8'h16, 1'b0, v); check(v == 16'h0000, "R3 reload bit clears", v, 16'h0000);
    wr(8'h13, 1'b0, 16'h0007);
    rd(8'h12, 1'b1, v); check(v == 16'h0700, "R2 threshold high byte", v, 16'h0700);
    wr(8'h12, 1'b1, 16'h0000);

    // R5 disabled: frozen
    rd(8'h10, 1'b1, c0); idle(5 * DIV); rd(8'h10, 1'b1, c1);
    check(c1 == c0, "R5 frozen while disabled", c1, c0);

    // R4 enabled: exact decrement
    wr(8'h16, 1'b0, 16'h0009);
    rd(8'h10, 1'b1, c0); idle(5 * DIV - 1); rd(8'h10, 1'b1, c1);
    check(c1 == c0 - 16'd5, "R4 five ticks", c1, c0 - 16'd5);
    rd(8'h10, 1'b1, c0); idle(9 * DIV - 1); rd(8'h10, 1'b1, c1);
    check(c1 == c0 - 16'd9, "R4 nine ticks", c1, c0 - 16'd9);

    // R5 clear enable, others kept
    wr(8'h16, 1'b0, 16'h0008);
    rd(8'h16, 1'b0, v); check(v == 16'h0008, "R5 nmi kept, enable off", v, 16'h0008);
    rd(8'h10, 1'b1, c0); idle(4 * DIV); rd(8'h10, 1'b1, c1);
    check(c1 == c0, "R5 stopped after clear", c1, c0);

    // R3 ping during countdown
    wr(8'h10, 1'b1, 16'd20);
    wr(8'h16, 1'b0, 16'h0005);
    base = pulses;
    idle(10 * DIV);
    wr(8'h16, 1'b0, 16'h0005);
    idle(1);
    rd(8'h10, 1'b1, v); check(v == 16'd20, "R3 ping restores preset", v, 16'd20);
    check(pulses == base, "R3 no expiry before ping", pulses, base);

    // R7 forced restart
    wr(8'h16, 1'b0, 16'h0000);
    wr(8'h10, 1'b1, 16'd1);
    base = pulses;
    wr(8'h16, 1'b0, 16'h0005);
    k = 0;
    while (pulses == base && k < DIV + 10) begin idle(1); k++; end
    check(k <= DIV + 2 && pulses == base + 1, "R7 forced expiry time", k, DIV + 2);
    idle(3 * DIV);
    check(pulses == base + 1, "R6 single pulse then hold", pulses, base + 1);
    rd(8'h10, 1'b1, v); check(v == 16'd0, "R6 holds at zero", v, 16'd0);
    rd(8'h16, 1'b0, v); check(v[0] == 1'b1, "R11 enable survives expiry", v, 16'h0001);

    // R8 R9 R10 warning without interrupt enable
    wr(8'h10, 1'b1, 16'd10);
    wr(8'h12, 1'b1, 16'd4);
    wr(8'h16, 1'b0, 16'h0085);
    wait_warn(12 * DIV, seen);
    rd(8'h10, 1'b1, v);
    check(seen && v == 16'd4, "R8 warning at threshold", v, 16'd4);
    check(!warn_irq, "R9 no irq without bit 3", warn_irq, 0);
    wr(8'h16, 1'b0, 16'h0000);
    rd(8'h16, 1'b0, v); check(v == 16'h0080, "R10 write 0 keeps warning", v, 16'h0080);
    wr(8'h16, 1'b0, 16'h0080);
    rd(8'h16, 1'b0, v); check(v == 16'h0000, "R10 write 1 clears", v, 16'h0000);

    // random presets and thresholds
    for (int it = 0; it < 24; it++) begin
      logic [15:0] p, t, lv;
      p = 16'(3 + ($urandom % 38));
      t = ($urandom % 2 == 0) ? 16'd0 : 16'(1 + ($urandom % (p - 1)));
      lv = exp_level(p, t);
      wr(8'h10, 1'b1, p);
      wr(8'h12, 1'b1, t);
      base = pulses;
      wr(8'h16, 1'b0, 16'h008D);
      wait_warn(int'(p) * DIV + 40, seen);
      rd(8'h10, 1'b1, v);
      check(seen && v == lv, "R8 random warning level", v, lv);
      check(warn_irq, "R9 irq with bit 3", warn_irq, 1);
      k = 0;
      while (pulses == base && k < int'(p) * DIV + 40) begin idle(1); k++; end
      idle(3);
      check(pulses == base + 1, "R6 random one pulse", pulses, base + 1);
      rd(8'h10, 1'b1, v); check(v == 16'd0, "R6 random zero", v, 16'd0);
      wr(8'h16, 1'b0, 16'h0080);
      check(!warn_irq, "R9 irq drops on clear", warn_irq, 0);
    end

    summary();
  end
endmodule